// File: doc/BRIEF.md
# Global FIFO DRAM Command Arbiter

This block is the command-issue stage of a DRAM controller shared by several requestors, each of which owns a private bank. Every requestor presents the head of its own command queue. When the block accepts that head, the command joins one shared ordering queue. Entries sit in that queue in the order they arrived, and this order gives every requestor a fair, rotating share of the command bus. On every cycle the block walks the shared queue from the oldest entry to the newest. It places the first entry that may legally go onto the single command bus.

Legality is split into two parts. The bank-local delays are checked when a command is accepted into the queue: the precharge-to-activate delay and the activate-to-column delay. The shared delays are checked when a command is picked: the read/write turnaround and data-bus occupancy. All delays come from configuration inputs that are held steady between resets. Every issued command is reported with its requestor and with the cycle on which its data burst completes.

Top module: `gfifo_cmd_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no command is issued and every requestor sees `req_ready` high.
- R2: At most one command is issued per cycle. A command issues exactly once, and only after it has been accepted.
- R3: The issued command is the oldest queued entry that is legal. Precharge (kind 0) and activate (kind 1) are always legal once queued. A read (kind 2) or write (kind 3) is legal only when the data-bus and turnaround delays have elapsed.
- R4: A requestor holds at most one queued entry. `req_ready` stays low while it has one, and it returns high no earlier than the cycle after that entry issues.
- R5: An activate from requestor i is accepted only when at least `cfg_t_rp` cycles have passed since requestor i's last precharge issued.
- R6: A read or write from requestor i is accepted only when at least `cfg_t_rcd` cycles have passed since requestor i's last activate issued.
- R7: Two column commands issue at least `cfg_t_burst` cycles apart. This applies in either direction.
- R8: A read issues at least `cfg_t_burst + cfg_t_wtr` cycles after the last write issued.
- R9: A write issues at least `cfg_t_burst + cfg_t_rtw` cycles after the last read issued.
- R10: `cmd_done` equals the issue cycle plus `cfg_t_burst` for reads and writes, and equals the issue cycle for row commands. The cycle count starts at 0 on the first cycle after reset and wraps at 2^CW.
- R11: When several requestors are accepted on the same cycle, they join the queue in ascending requestor index.

The kind of requestor i is carried in `req_kind[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_t_rp | input | TW | Precharge-to-activate delay, cycles |
| cfg_t_rcd | input | TW | Activate-to-column delay, cycles |
| cfg_t_wtr | input | TW | Extra write-to-read turnaround after the burst |
| cfg_t_rtw | input | TW | Extra read-to-write turnaround after the burst |
| cfg_t_burst | input | TW | Data-bus occupancy of one column command |
| req_valid | input | NREQ | Requestor i presents a command |
| req_kind | input | 2*NREQ | Kind of each requestor's command (0 PRE, 1 ACT, 2 RD, 3 WR) |
| req_ready | output | NREQ | Requestor i's command may be accepted this cycle |
| cmd_valid | output | 1 | A command is placed on the command bus |
| cmd_kind | output | 2 | Kind of the issued command |
| cmd_req | output | $clog2(NREQ) | Requestor, and hence bank, of the issued command |
| cmd_done | output | CW | Cycle on which the command's data completes |

## Verification
The bench uses four requestors, 4-bit delay fields and a 16-bit cycle count. It runs three timing sets, each after a fresh reset. The first is a middling set. The second is the minimum set, with a burst of one and zero turnarounds, where a write can be followed by a read on the very next cycle. The third is a long set with a write-heavy mix. Idle gaps in the requestors' streams let the queue drain to empty and fill to full. The PRE/ACT/column bursts place row commands behind blocked column commands, so the scan must skip stuck entries, and several requestors are often accepted on one cycle.

// File: rtl/gca_pkg.sv
package gca_pkg;

  typedef enum logic [1:0] {
    CK_PRE = 2'd0,
    CK_ACT = 2'd1,
    CK_RD  = 2'd2,
    CK_WR  = 2'd3
  } cmd_kind_e;

  function automatic logic is_col(input cmd_kind_e k);
    return (k == CK_RD) || (k == CK_WR);
  endfunction

endpackage

// File: rtl/gca_bank_timer.sv
module gca_bank_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_fire,
  input  logic          act_fire,
  input  logic          col_fire,
  input  logic [TW-1:0] cfg_t_rp,
  input  logic [TW-1:0] cfg_t_rcd,
  output logic          act_ok,
  output logic          col_ok
);

  function automatic logic [TW-1:0] ld(input logic [TW-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  logic [TW-1:0] rp_q, rp_n, rcd_q, rcd_n;
  logic          rp_en, rcd_en;

  always_comb begin
    rp_en  = pre_fire || (rp_q != '0);
    rcd_en = act_fire || (rcd_q != '0);
    rp_n   = pre_fire ? ld(cfg_t_rp)  : rp_q - 1'b1;
    rcd_n  = act_fire ? ld(cfg_t_rcd) : rcd_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      rcd_q <= '0;
    end else begin
      if (rp_en)  rp_q  <= rp_n;
      if (rcd_en) rcd_q <= rcd_n;
    end
  end

  assign act_ok = (rp_q == '0);
  assign col_ok = (rcd_q == '0);

  assert_act_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> act_ok);
  assert_col_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    col_fire |-> col_ok);

endmodule

// File: rtl/gca_bus_timer.sv
module gca_bus_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          wr_fire,
  input  logic [TW-1:0] cfg_t_burst,
  input  logic [TW-1:0] cfg_t_wtr,
  input  logic [TW-1:0] cfg_t_rtw,
  output logic          rd_ok,
  output logic          wr_ok
);

  localparam int CTW = TW + 1;

  function automatic logic [CTW-1:0] ld(input logic [CTW-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  logic [CTW-1:0] bus_q, bus_n, wtr_q, wtr_n, rtw_q, rtw_n;
  logic [CTW-1:0] burst_w, wtr_sum, rtw_sum;
  logic           bus_en, wtr_en, rtw_en;

  always_comb begin
    burst_w = {1'b0, cfg_t_burst};
    wtr_sum = burst_w + {1'b0, cfg_t_wtr};
    rtw_sum = burst_w + {1'b0, cfg_t_rtw};
    bus_en  = rd_fire || wr_fire || (bus_q != '0);
    wtr_en  = wr_fire || (wtr_q != '0);
    rtw_en  = rd_fire || (rtw_q != '0);
    bus_n   = (rd_fire || wr_fire) ? ld(burst_w) : bus_q - 1'b1;
    wtr_n   = wr_fire ? ld(wtr_sum) : wtr_q - 1'b1;
    rtw_n   = rd_fire ? ld(rtw_sum) : rtw_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      wtr_q <= '0;
      rtw_q <= '0;
    end else begin
      if (bus_en) bus_q <= bus_n;
      if (wtr_en) wtr_q <= wtr_n;
      if (rtw_en) rtw_q <= rtw_n;
    end
  end

  assign rd_ok = (bus_q == '0) && (wtr_q == '0);
  assign wr_ok = (bus_q == '0) && (rtw_q == '0);

  assert_one_column_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_fire, wr_fire}));
  assert_burst_gap_R7: assert property (@(posedge clk)
    disable iff (!rst_n || (burst_w < CTW'(2)))
    (rd_fire || wr_fire) |=> !(rd_fire || wr_fire));
  assert_wr_to_rd_R8: assert property (@(posedge clk)
    disable iff (!rst_n || (wtr_sum < CTW'(2)))
    wr_fire |=> !rd_fire);
  assert_rd_to_wr_R9: assert property (@(posedge clk)
    disable iff (!rst_n || (rtw_sum < CTW'(2)))
    rd_fire |=> !wr_fire);

endmodule

// File: rtl/gca_order_queue.sv
module gca_order_queue #(
  parameter int NREQ = 4,
  parameter int IW   = $clog2(NREQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pop_en,
  input  logic [IW-1:0]             pop_idx,
  input  logic [NREQ-1:0]           push_vec,
  input  logic [NREQ-1:0][1:0]      push_kind,
  output logic [IW:0]               cnt,
  output logic [NREQ-1:0][IW-1:0]   slot_req,
  output logic [NREQ-1:0][1:0]      slot_kind,
  output logic [NREQ-1:0]           pend_vec
);

  localparam logic [IW:0] DEPTH = (IW+1)'(NREQ);

  logic [IW:0]             cnt_q, cnt_n, pos;
  logic [NREQ-1:0][IW-1:0] req_q, req_n;
  logic [NREQ-1:0][1:0]    kind_q, kind_n;
  logic                    q_en;

  always_comb begin
    req_n  = req_q;
    kind_n = kind_q;
    for (int j = 0; j < NREQ - 1; j++) begin
      if (pop_en && ((IW+1)'(j) >= {1'b0, pop_idx})) begin
        req_n[j]  = req_q[j+1];
        kind_n[j] = kind_q[j+1];
      end
    end
    pos = cnt_q - {{IW{1'b0}}, pop_en};
    for (int i = 0; i < NREQ; i++) begin
      if (push_vec[i]) begin
        if (pos < DEPTH) begin
          req_n[pos[IW-1:0]]  = IW'(i);
          kind_n[pos[IW-1:0]] = push_kind[i];
        end
        pos = pos + 1'b1;
      end
    end
    cnt_n = pos;
    q_en  = pop_en || (push_vec != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      req_q  <= '0;
      kind_q <= '0;
    end else if (q_en) begin
      cnt_q  <= cnt_n;
      req_q  <= req_n;
      kind_q <= kind_n;
    end
  end

  always_comb begin
    pend_vec = '0;
    for (int j = 0; j < NREQ; j++) begin
      if ((IW+1)'(j) < cnt_q) pend_vec[req_q[j]] = 1'b1;
    end
  end

  assign cnt       = cnt_q;
  assign slot_req  = req_q;
  assign slot_kind = kind_q;

  assert_depth_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH);
  assert_single_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vec & pend_vec) == '0);
  assert_pop_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> ({1'b0, pop_idx} < cnt_q));

endmodule

// File: rtl/gfifo_cmd_arbiter.sv
module gfifo_cmd_arbiter
  import gca_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int TW   = 4,
  parameter int CW   = 16,
  parameter int IW   = $clog2(NREQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TW-1:0]       cfg_t_rp,
  input  logic [TW-1:0]       cfg_t_rcd,
  input  logic [TW-1:0]       cfg_t_wtr,
  input  logic [TW-1:0]       cfg_t_rtw,
  input  logic [TW-1:0]       cfg_t_burst,
  input  logic [NREQ-1:0]     req_valid,
  input  logic [2*NREQ-1:0]   req_kind,
  output logic [NREQ-1:0]     req_ready,
  output logic                cmd_valid,
  output logic [1:0]          cmd_kind,
  output logic [IW-1:0]       cmd_req,
  output logic [CW-1:0]       cmd_done
);

  logic [IW:0]             q_cnt;
  logic [NREQ-1:0][IW-1:0] q_req;
  logic [NREQ-1:0][1:0]    q_kind;
  logic [NREQ-1:0]         q_pend;
  logic [NREQ-1:0]         push_vec;
  logic [NREQ-1:0][1:0]    push_kind;
  logic [NREQ-1:0]         act_ok, col_ok;
  logic [NREQ-1:0]         pre_fire, act_fire, col_fire;
  logic [NREQ-1:0]         slot_legal;
  logic                    rd_ok, wr_ok, rd_fire, wr_fire;
  logic                    pick_any;
  logic [IW-1:0]           pick_idx;
  cmd_kind_e               iss_kind;
  logic [IW-1:0]           iss_req;
  logic [CW-1:0]           cyc_q, cyc_n;

  // acceptance: bank-local delays are settled before a command may queue
  for (genvar i = 0; i < NREQ; i++) begin : g_req
    cmd_kind_e k;
    logic      gate;
    assign k            = cmd_kind_e'(req_kind[2*i +: 2]);
    assign gate         = (k == CK_ACT) ? act_ok[i] : (is_col(k) ? col_ok[i] : 1'b1);
    assign req_ready[i] = !q_pend[i] && gate;
    assign push_vec[i]  = req_valid[i] && req_ready[i];
    assign push_kind[i] = req_kind[2*i +: 2];

    assign pre_fire[i] = pick_any && (iss_kind == CK_PRE) && (iss_req == IW'(i));
    assign act_fire[i] = pick_any && (iss_kind == CK_ACT) && (iss_req == IW'(i));
    assign col_fire[i] = pick_any && is_col(iss_kind)     && (iss_req == IW'(i));

    gca_bank_timer #(.TW(TW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pre_fire  (pre_fire[i]),
      .act_fire  (act_fire[i]),
      .col_fire  (col_fire[i]),
      .cfg_t_rp  (cfg_t_rp),
      .cfg_t_rcd (cfg_t_rcd),
      .act_ok    (act_ok[i]),
      .col_ok    (col_ok[i])
    );
  end

  gca_order_queue #(.NREQ(NREQ), .IW(IW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_en    (pick_any),
    .pop_idx   (pick_idx),
    .push_vec  (push_vec),
    .push_kind (push_kind),
    .cnt       (q_cnt),
    .slot_req  (q_req),
    .slot_kind (q_kind),
    .pend_vec  (q_pend)
  );

  gca_bus_timer #(.TW(TW)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (rd_fire),
    .wr_fire     (wr_fire),
    .cfg_t_burst (cfg_t_burst),
    .cfg_t_wtr   (cfg_t_wtr),
    .cfg_t_rtw   (cfg_t_rtw),
    .rd_ok       (rd_ok),
    .wr_ok       (wr_ok)
  );

  // scan: shared delays decide which queued entry may go
  for (genvar j = 0; j < NREQ; j++) begin : g_slot
    cmd_kind_e sk;
    assign sk = cmd_kind_e'(q_kind[j]);
    assign slot_legal[j] = ((IW+1)'(j) < q_cnt) &&
                           ((sk == CK_RD) ? rd_ok :
                            (sk == CK_WR) ? wr_ok : 1'b1);
  end

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int j = NREQ - 1; j >= 0; j--) begin
      if (slot_legal[j]) begin
        pick_any = 1'b1;
        pick_idx = IW'(j);
      end
    end
    iss_kind = cmd_kind_e'(q_kind[pick_idx]);
    iss_req  = q_req[pick_idx];
    rd_fire  = pick_any && (iss_kind == CK_RD);
    wr_fire  = pick_any && (iss_kind == CK_WR);
    cyc_n    = cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_n;
  end

  assign cmd_valid = pick_any;
  assign cmd_kind  = iss_kind;
  assign cmd_req   = iss_req;
  assign cmd_done  = cyc_q + (is_col(iss_kind) ? CW'(cfg_t_burst) : '0);

  assert_front_row_goes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_cnt != '0) && !q_kind[0][1]) |-> cmd_valid);
  assert_act_then_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == CK_ACT)) |=>
      !(cmd_valid && cmd_kind[1] && (cmd_req == $past(cmd_req))));
  assert_idle_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == '0) |-> !cmd_valid);

endmodule

// File: tb/sim_gfifo_cmd_arbiter.sv
module sim_gfifo_cmd_arbiter;
  localparam int NREQ = 4;
  localparam int TW   = 4;
  localparam int CW   = 16;
  localparam int IW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [TW-1:0]     cfg_t_rp, cfg_t_rcd, cfg_t_wtr, cfg_t_rtw, cfg_t_burst;
  logic [NREQ-1:0]   req_valid;
  logic [2*NREQ-1:0] req_kind;
  logic [NREQ-1:0]   req_ready;
  logic              cmd_valid;
  logic [1:0]        cmd_kind;
  logic [IW-1:0]     cmd_req;
  logic [CW-1:0]     cmd_done;

  gfifo_cmd_arbiter #(.NREQ(NREQ), .TW(TW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_t_rp(cfg_t_rp), .cfg_t_rcd(cfg_t_rcd), .cfg_t_wtr(cfg_t_wtr),
    .cfg_t_rtw(cfg_t_rtw), .cfg_t_burst(cfg_t_burst),
    .req_valid(req_valid), .req_kind(req_kind), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_req(cmd_req),
    .cmd_done(cmd_done)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  int q [NREQ][$];
  int m_fifo [$];
  int m_kind [NREQ];
  bit m_inq [NREQ];
  int m_rp [NREQ], m_rcd [NREQ];
  int m_bus, m_wtr, m_rtw, m_cyc;
  int c_rp, c_rcd, c_wtr, c_rtw, c_burst, wr_pct, idle_pct;
  bit acc [NREQ];
  int last_col, last_rd, last_wr;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ld(int d);
    return (d == 0) ? 0 : d - 1;
  endfunction

  task automatic refill(int i);
    if ($urandom % 3 == 0) begin
      q[i].push_back(0);
      q[i].push_back(1);
    end
    q[i].push_back(($urandom % 100 < wr_pct) ? 3 : 2);
  endtask

  task automatic drive_inputs();
    for (int i = 0; i < NREQ; i++) begin
      if (q[i].size() == 0) refill(i);
      req_valid[i] = ($urandom % 100) >= idle_pct;
      req_kind[2*i +: 2] = req_valid[i] ? q[i][0][1:0] : 2'd0;
    end
  endtask

  task automatic model_reset();
    m_fifo.delete();
    for (int i = 0; i < NREQ; i++) begin
      m_inq[i] = 0; m_rp[i] = 0; m_rcd[i] = 0; m_kind[i] = 0;
      q[i].delete();
    end
    m_bus = 0; m_wtr = 0; m_rtw = 0; m_cyc = 0;
    last_col = -1000; last_rd = -1000; last_wr = -1000;
  endtask

  task automatic step();
    int pick, r, k, kn;
    bit ok, er;
    string tg;
    @(negedge clk);
    pick = -1;
    for (int idx = 0; idx < m_fifo.size(); idx++) begin
      k = m_kind[m_fifo[idx]];
      ok = (k < 2) || (k == 2 && m_bus == 0 && m_wtr == 0) ||
           (k == 3 && m_bus == 0 && m_rtw == 0);
      if (ok && pick < 0) pick = idx;
    end
    check(cmd_valid === (pick >= 0), "R2", "issue valid", cmd_valid, pick >= 0);
    if (pick >= 0 && cmd_valid === 1'b1) begin
      r = m_fifo[pick];
      k = m_kind[r];
      check(cmd_req == r, "R3,R11", "issued requestor", cmd_req, r);
      check(cmd_kind == k, "R3", "issued kind", cmd_kind, k);
      check(cmd_done == ((m_cyc + (k >= 2 ? c_burst : 0)) % 65536), "R10",
            "done cycle", cmd_done, (m_cyc + (k >= 2 ? c_burst : 0)) % 65536);
    end
    for (int i = 0; i < NREQ; i++) begin
      kn = req_kind[2*i +: 2];
      er = !m_inq[i] && ((kn == 1) ? (m_rp[i] == 0) : (kn >= 2) ? (m_rcd[i] == 0) : 1'b1);
      tg = m_inq[i] ? "R4" : (kn == 1) ? "R5" : (kn >= 2) ? "R6" : "R4";
      check(req_ready[i] === er, tg, "ready", req_ready[i], er);
      acc[i] = req_valid[i] && er;
    end
    if (cmd_valid === 1'b1 && cmd_kind >= 2) begin
      check(m_cyc - last_col >= c_burst, "R7", "column gap", m_cyc - last_col, c_burst);
      if (cmd_kind == 2)
        check(m_cyc - last_wr >= c_burst + c_wtr, "R8", "write-to-read gap",
              m_cyc - last_wr, c_burst + c_wtr);
      else
        check(m_cyc - last_rd >= c_burst + c_rtw, "R9", "read-to-write gap",
              m_cyc - last_rd, c_burst + c_rtw);
      last_col = m_cyc;
      if (cmd_kind == 2) last_rd = m_cyc; else last_wr = m_cyc;
    end
    // advance the model to the coming edge
    if (m_bus > 0) m_bus--;
    if (m_wtr > 0) m_wtr--;
    if (m_rtw > 0) m_rtw--;
    for (int i = 0; i < NREQ; i++) begin
      if (m_rp[i] > 0) m_rp[i]--;
      if (m_rcd[i] > 0) m_rcd[i]--;
    end
    if (pick >= 0) begin
      r = m_fifo[pick];
      k = m_kind[r];
      case (k)
        0: m_rp[r] = ld(c_rp);
        1: m_rcd[r] = ld(c_rcd);
        2: begin m_bus = ld(c_burst); m_rtw = ld(c_burst + c_rtw); end
        default: begin m_bus = ld(c_burst); m_wtr = ld(c_burst + c_wtr); end
      endcase
      m_fifo.delete(pick);
      m_inq[r] = 0;
    end
    for (int i = 0; i < NREQ; i++) begin
      if (acc[i]) begin
        m_fifo.push_back(i);
        m_inq[i] = 1;
        m_kind[i] = req_kind[2*i +: 2];
      end
    end
    m_cyc++;
    @(posedge clk);
    #1;
    for (int i = 0; i < NREQ; i++) if (acc[i]) void'(q[i].pop_front());
    drive_inputs();
  endtask

  task automatic phase(int rp, int rcd, int wtr, int rtw, int bl, int wp, int ip, int n);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    req_valid = '0;
    req_kind = '0;
    c_rp = rp; c_rcd = rcd; c_wtr = wtr; c_rtw = rtw; c_burst = bl;
    wr_pct = wp; idle_pct = ip;
    cfg_t_rp = TW'(rp); cfg_t_rcd = TW'(rcd); cfg_t_wtr = TW'(wtr);
    cfg_t_rtw = TW'(rtw); cfg_t_burst = TW'(bl);
    repeat (3) @(negedge clk);
    check(cmd_valid === 1'b0, "R1", "valid in reset", cmd_valid, 0);
    check(req_ready === '1, "R1", "ready in reset", req_ready, 15);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    model_reset();
    drive_inputs();
    repeat (n) step();
  endtask

  initial begin
    req_valid = '0;
    req_kind = '0;
    cfg_t_rp = '0; cfg_t_rcd = '0; cfg_t_wtr = '0; cfg_t_rtw = '0; cfg_t_burst = '1;
    phase(3, 2, 3, 1, 2, 40, 20, 2000);
    phase(1, 1, 0, 0, 1, 50, 10, 2000);
    phase(6, 5, 5, 2, 4, 75, 35, 2000);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0 (run did not finish)");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule